// File: doc/BRIEF.md
# Tap-Selectable Timer and Frequency Divider

A synchronous timer built on a 16-stage binary up-counter that advances on every rising clock edge. A 2-bit tap select picks one of four counter stages. That stage drives a single registered output. Two modes are available. In divider mode the output is a continuous square wave with a period of 2^n clocks. In single-transition mode the output flips once, after 2^(n-1) counts, and then stays latched.

A phase input sets the polarity of the output. A master reset clears the counter and the latch. An optional power-on reset is a one-shot pulse that is counted out in the clock domain after the system reset releases. It is armed only when both the auto-reset-disable input and the master reset are low. Address changes are registered, so a new tap takes effect one edge later and the output cannot glitch.

Top module: `prog_timer_top`

## Requirements
- R1: While no reset source (rst, mr, power-on pulse) is active, the counter increases by one on every rising clock edge, so the counter equals k after the k-th edge following reset release.
- R2: A high mr at a clock edge clears the counter and the single-shot latch, and sets the output to the current phase level. Counting restarts from zero on the first edge with mr low.
- R3: The tap select maps tap_sel[1:0] (bit 0 = A0, bit 1 = A1) to stage count n as follows: 2'b00 gives 13, 2'b10 gives 10, 2'b01 gives 8, and 2'b11 gives 16.
- R4: With mode high, after each edge the output equals counter bit n-1 XOR phase. This is a 50% duty wave with a period of 2^n clocks.
- R5: With mode low, the output leaves the phase level on the edge where the counter reaches 2^(n-1), and then stays there while mode remains low.
- R6: A rising edge of mode, detected against a registered copy of mode, clears the single-shot latch. A later return to mode low restarts the one-shot from the phase level.
- R7: After any reset the output equals phase (low for phase=0, high for phase=1), and phase inverts the output in both modes.
- R8: If ar_n and mr are both low on the first edge after rst releases, a power-on reset pulse holds the counter cleared for POR_CYCLES edges. With defaults, the single-shot output for n=8 rises on edge 145 instead of edge 128.
- R9: A high ar_n on the first edge after rst releases disables the power-on pulse entirely.
- R10: A change of tap_sel takes effect on the second edge after the change. The first edge still uses the old tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| mr | input | 1 | Master reset, active high |
| ar_n | input | 1 | High disables the power-on pulse |
| mode | input | 1 | 1 = divider, 0 = single transition |
| phase | input | 1 | Output polarity |
| tap_sel | input | 2 | Tap select, bit 0 = A0, bit 1 = A1 |
| tmr_out | output | 1 | Registered timer output |

## Verification
Several properties hold on every cycle and are checked that way: the counter steps by one outside reset, a master reset clears the count and loads the phase level, the latch holds once set in single mode, a rising mode edge clears the latch, and the divider output tracks the selected counter bit. Other behaviour can only be shown by the bench's scenarios. These are the absolute tap map over long runs, the exact edge on which the one-shot fires, the length and gating of the power-on pulse, and the one-edge delay of a tap change.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;
  typedef enum logic [1:0] {
    POR_CHECK = 2'd0,
    POR_PULSE = 2'd1,
    POR_DONE  = 2'd2
  } por_state_e;
endpackage

// File: rtl/ptm_por.sv
module ptm_por #(
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ar_n,
  input  logic mr,
  output logic por_o
);
  import prog_timer_pkg::*;
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  por_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          por_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= POR_CHECK;
      cnt_q <= '0;
      por_q <= 1'b0;
    end else begin
      case (st_q)
        POR_CHECK: begin
          if (!ar_n && !mr) begin
            por_q <= 1'b1;
            cnt_q <= CW'(1);
            st_q  <= POR_PULSE;
          end else begin
            st_q <= POR_DONE;
          end
        end
        POR_PULSE: begin
          if (cnt_q == CW'(POR_CYCLES)) begin
            por_q <= 1'b0;
            st_q  <= POR_DONE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          por_q <= 1'b0;
        end
      endcase
    end
  end

  assign por_o = por_q;
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             clr,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    if (clr) nxt = '0;
    else     nxt = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk) begin
    cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/ptm_tap_sel.sv
module ptm_tap_sel #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned STG_SEL0 = 13,
  parameter int unsigned STG_SEL1 = 8,
  parameter int unsigned STG_SEL2 = 10,
  parameter int unsigned STG_SEL3 = 16
) (
  input  logic             clk,
  input  logic [1:0]       tap_sel,
  output logic [IDX_W-1:0] tap_idx_o
);
  localparam int unsigned STG [4] = '{STG_SEL0, STG_SEL1, STG_SEL2, STG_SEL3};

  logic [IDX_W-1:0] idx_lut [4];
  logic [1:0]       sel_q;

  for (genvar i = 0; i < 4; i++) begin : g_lut
    assign idx_lut[i] = IDX_W'(STG[i] - 1);
  end

  always_ff @(posedge clk) begin
    sel_q <= tap_sel;
  end

  assign tap_idx_o = idx_lut[sel_q];
endmodule

// File: rtl/ptm_out_stage.sv
module ptm_out_stage #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             mode,
  input  logic             phase,
  input  logic [WIDTH-1:0] nxt,
  input  logic [IDX_W-1:0] tap_idx,
  output logic             out_o,
  output logic             fired_o
);
  logic mode_q;
  logic fired_q;
  logic out_q;
  logic mode_rise;
  logic bit_sel;
  logic fired_d;
  logic out_d;

  assign mode_rise = mode & ~mode_q;
  assign bit_sel   = nxt[tap_idx];

  always_comb begin
    if (clr || mode_rise) fired_d = 1'b0;
    else                  fired_d = fired_q | (~mode & bit_sel);
    out_d = (mode ? bit_sel : fired_d) ^ phase;
  end

  always_ff @(posedge clk) begin
    mode_q  <= mode;
    fired_q <= fired_d;
    out_q   <= out_d;
  end

  assign out_o   = out_q;
  assign fired_o = fired_q;
endmodule

// File: rtl/prog_timer_top.sv
module prog_timer_top #(
  parameter int unsigned WIDTH      = 16,
  parameter int unsigned POR_CYCLES = 16,
  parameter int unsigned STG_SEL0   = 13,
  parameter int unsigned STG_SEL1   = 8,
  parameter int unsigned STG_SEL2   = 10,
  parameter int unsigned STG_SEL3   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mr,
  input  logic       ar_n,
  input  logic       mode,
  input  logic       phase,
  input  logic [1:0] tap_sel,
  output logic       tmr_out
);
  localparam int unsigned IDX_W = $clog2(WIDTH);

  logic             por_w;
  logic             clr_w;
  logic [WIDTH-1:0] cnt_w;
  logic [WIDTH-1:0] nxt_w;
  logic [IDX_W-1:0] tap_idx_w;
  logic             fired_w;

  ptm_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .ar_n(ar_n), .mr(mr), .por_o(por_w)
  );

  assign clr_w = rst | mr | por_w;

  ptm_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .clr(clr_w), .cnt_o(cnt_w), .nxt_o(nxt_w)
  );

  ptm_tap_sel #(
    .IDX_W(IDX_W), .STG_SEL0(STG_SEL0), .STG_SEL1(STG_SEL1),
    .STG_SEL2(STG_SEL2), .STG_SEL3(STG_SEL3)
  ) u_tap (
    .clk(clk), .tap_sel(tap_sel), .tap_idx_o(tap_idx_w)
  );

  ptm_out_stage #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_out (
    .clk(clk), .clr(clr_w), .mode(mode), .phase(phase), .nxt(nxt_w),
    .tap_idx(tap_idx_w), .out_o(tmr_out), .fired_o(fired_w)
  );
endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mr,
  input logic             mode,
  input logic             phase,
  input logic             tmr_out,
  input logic             por,
  input logic             fired,
  input logic [WIDTH-1:0] cnt,
  input logic [IDX_W-1:0] tap_idx
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!mr && !por) |=> cnt == WIDTH'($past(cnt) + WIDTH'(1))); // R1

  AST_MR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mr |=> (cnt == '0 && tmr_out == $past(phase))); // R2

  AST_DIV_TRACK: assert property (@(posedge clk) disable iff (rst)
    (mode && !mr && !por) |=> tmr_out == (cnt[$past(tap_idx)] ^ $past(phase))); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mode && !mr && !por && fired) |=> fired); // R5

  AST_MODE_RISE_CLR: assert property (@(posedge clk) disable iff (rst)
    $rose(mode) |=> !fired); // R6
endmodule

bind prog_timer_top ptm_checker #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .mr(mr), .mode(mode), .phase(phase),
  .tmr_out(tmr_out), .por(por_w), .fired(fired_w), .cnt(cnt_w),
  .tap_idx(tap_idx_w)
);

// File: tb/prog_timer_top_tb.sv
`timescale 1ns/1ps
module prog_timer_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mr = 1'b0;
  logic       ar_n = 1'b1;
  logic       mode = 1'b0;
  logic       phase = 1'b0;
  logic [1:0] tap_sel = 2'b01;
  logic       tmr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prog_timer_top u_dut (
    .clk(clk), .rst(rst), .mr(mr), .ar_n(ar_n), .mode(mode),
    .phase(phase), .tap_sel(tap_sel), .tmr_out(tmr_out)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic start(input logic m, input logic ph, input logic [1:0] sel,
                       input logic arn);
    @(posedge clk); #1;
    rst = 1'b1; mr = 1'b0; mode = m; phase = ph; tap_sel = sel; ar_n = arn;
    step(2);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    start(1'b0, 1'b0, 2'b01, 1'b1);
    check("R7 reset ph0", tmr_out, 1'b0);
    start(1'b0, 1'b1, 2'b01, 1'b1);
    check("R7 reset ph1", tmr_out, 1'b1);
  endtask

  task automatic t_single();
    start(1'b0, 1'b0, 2'b01, 1'b1);
    step(127); check("R5 before 128", tmr_out, 1'b0);
    step(1);   check("R5 at 128 R1", tmr_out, 1'b1);
    step(200); check("R5 latched", tmr_out, 1'b1);
    start(1'b0, 1'b1, 2'b01, 1'b1);
    step(127); check("R7 inv before", tmr_out, 1'b1);
    step(1);   check("R7 inv fired", tmr_out, 1'b0);
  endtask

  task automatic t_divider();
    start(1'b1, 1'b0, 2'b01, 1'b1);
    step(127); check("R4 k127", tmr_out, 1'b0);
    step(1);   check("R4 k128", tmr_out, 1'b1);
    step(127); check("R4 k255", tmr_out, 1'b1);
    step(1);   check("R4 k256", tmr_out, 1'b0);
    step(128); check("R4 k384", tmr_out, 1'b1);
    start(1'b1, 1'b1, 2'b01, 1'b1);
    step(128); check("R7 div inv k128", tmr_out, 1'b0);
  endtask

  task automatic t_taps();
    logic [1:0] sels [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
    int         half [4] = '{4096, 512, 128, 32768};
    for (int i = 0; i < 4; i++) begin
      start(1'b0, 1'b0, sels[i], 1'b1);
      step(half[i] - 1); check("R3 tap before", tmr_out, 1'b0);
      step(1);           check("R3 tap fire", tmr_out, 1'b1);
    end
  endtask

  task automatic t_master_reset();
    start(1'b0, 1'b0, 2'b01, 1'b1);
    step(200); check("R2 pre", tmr_out, 1'b1);
    mr = 1'b1; phase = 1'b0;
    step(1); check("R2 mr out", tmr_out, 1'b0);
    step(3); check("R2 mr held", tmr_out, 1'b0);
    mr = 1'b0;
    step(127); check("R2 restart 127", tmr_out, 1'b0);
    step(1);   check("R2 restart 128", tmr_out, 1'b1);
  endtask

  task automatic t_mode_rise();
    start(1'b0, 1'b0, 2'b01, 1'b1);
    step(300); check("R6 fired", tmr_out, 1'b1);
    mode = 1'b1;
    step(1); check("R6 div k301", tmr_out, 1'b0);
    mode = 1'b0;
    step(1);  check("R6 cleared k302", tmr_out, 1'b0);
    step(81); check("R6 k383", tmr_out, 1'b0);
    step(1);  check("R6 refire k384", tmr_out, 1'b1);
  endtask

  task automatic t_tap_change();
    start(1'b1, 1'b0, 2'b01, 1'b1);
    step(200); check("R10 k200 n8", tmr_out, 1'b1);
    tap_sel = 2'b10;
    step(1); check("R10 old tap k201", tmr_out, 1'b1);
    step(1); check("R10 new tap k202", tmr_out, 1'b0);
  endtask

  task automatic t_por();
    start(1'b0, 1'b0, 2'b01, 1'b0);
    step(144); check("R8 por 144", tmr_out, 1'b0);
    step(1);   check("R8 por 145", tmr_out, 1'b1);
    start(1'b0, 1'b0, 2'b01, 1'b1);
    step(127); check("R9 no por 127", tmr_out, 1'b0);
    step(1);   check("R9 no por 128", tmr_out, 1'b1);
  endtask

  initial begin
    step(3);
    t_reset_state();
    t_single();
    t_divider();
    t_taps();
    t_master_reset();
    t_mode_rise();
    t_tap_change();
    t_por();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule